// File: doc/BRIEF.md
# Resynchronising Serial Byte Receiver

This block takes one asynchronous serial line that carries 8N1 characters: a low start bit, eight data bits with the least significant bit first, and a high stop bit. It turns each good character into a parallel byte for the host. The receiver does not assume any phase or frequency relation between its own clock and the sender's bit clock. While idle it inspects the synchronised line on every system clock cycle. Each falling start edge it finds restarts the bit timer, so every character is timed from its own start edge.

The receiver checks the start bit half a bit period after the falling edge, at its centre. It then samples each data bit at its centre, and samples the stop bit one bit period after the last data bit. A character whose stop bit reads low is thrown away. The newest good byte sits in a holding register with a valid flag, and a one-cycle read strobe from the host clears that flag. A byte that arrives while the previous one is still unread replaces it.

Clock rate and bit rate are parameters, so several copies can run side by side at different rates. The block derives `BIT_CLKS = CLK_HZ / BAUD` and `HALF_CLKS = BIT_CLKS / 2`, and it needs `BIT_CLKS >= 4`.

The control is a four-state machine:
- HUNT: idle, watching the line.
- START: qualifying the start bit.
- DATA: collecting the eight data bits.
- STOP: checking the stop bit.

Its transitions are:
- HUNT→START when the synchronised line reads low.
- START→HUNT on the half-bit strobe if the line is high again (a glitch).
- START→DATA on the half-bit strobe if the line is still low.
- DATA→DATA on each bit strobe before the eighth.
- DATA→STOP on the eighth bit strobe.
- STOP→HUNT on the next bit strobe, whatever the stop bit reads.

Top module: `serial_rx_latest`

## Requirements
- R1: After reset `valid_o` is 0, `data_o` is 0x00 and the receiver is hunting for a start edge.
- R2: A well-formed 8N1 frame (start 0, data least significant bit first, stop 1) loads its byte into `data_o` and sets `valid_o`.
- R3: `valid_o` first reads 1 after clock edge number 4 + HALF_CLKS + 9·BIT_CLKS, counted from the first edge that samples the RX input low. That count covers two synchroniser stages, the start, data and stop sampling points, and one cycle for the holding register.
- R4: A low pulse on RX that has ended before the half-bit check is rejected: `data_o` and `valid_o` keep their values.
- R5: A frame whose stop bit samples low changes neither `data_o` nor `valid_o`.
- R6: A good frame that arrives while `valid_o` is still 1 overwrites `data_o` with the new byte, and `valid_o` stays 1.
- R7: A read strobe (`rd_i` high for one clock) clears `valid_o` at the next edge and never changes `data_o`. A read while `valid_o` is 0 has no effect.
- R8: When a read strobe and a new byte load meet at the same clock edge, the new byte is stored and `valid_o` stays 1.
- R9: The start edge is searched for on every clock cycle, so the latency of R3 is the same whatever clock phase the falling edge arrives at. The bit-timing strobe never pulses while hunting.
- R10: Bit timing restarts on every start edge, so frames sent back-to-back at a bit period 3 % shorter or longer than BIT_CLKS are all received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idles high |
| rd_i | input | 1 | Host read strobe, clears the valid flag |
| data_o | output | DATA_W | Most recently received good byte |
| valid_o | output | 1 | Set when a byte has arrived since the last read |

## Verification
The bench goes after the edges of the timing window and of the handshake:
- A start glitch that ends just before the half-bit check. A design that does not qualify the start bit would report a zero byte.
- A bad stop bit. A design that ignored framing would overwrite the stored byte.
- Two unread bytes in a row. A design that keeps the oldest byte would show stale data.
- A read strobe timed onto the very load edge. A design that gives the read priority would lose the new byte's flag.
- Start edges placed at every clock offset, and back-to-back frames from a sender running 3 % fast or slow. A receiver that only looked at the line on a divided tick, or that did not restart timing per frame, would drift onto a bit boundary and return corrupted bytes or shifted latencies.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
// Flop chain that brings the asynchronous line into the clock domain.
module srx_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/srx_timer.sv
// Bit-timing strobe taken straight from a flop. While restart is held the
// counter is preloaded so that the first strobe reaches the state machine
// HALF_CLKS edges after restart drops, and later strobes come every BIT_CLKS.
module srx_timer #(
    parameter int BIT_CLKS  = 52,
    parameter int HALF_CLKS = 26
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;
    localparam logic [CW-1:0] FIRST_LOAD = CW'(HALF_CLKS - 2);
    localparam logic [CW-1:0] BIT_LOAD   = CW'(BIT_CLKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= FIRST_LOAD;
            tick <= 1'b0;
        end else if (restart) begin
            cnt  <= FIRST_LOAD;
            tick <= 1'b0;
        end else if (cnt == '0) begin
            cnt  <= BIT_LOAD;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt - 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/srx_frame.sv
// Frame state machine: start qualification, data shifting, stop check.
module srx_frame
    import srx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic              tick,
    output logic              hunting,
    output logic              byte_ok,
    output logic [DATA_W-1:0] byte_data
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(DATA_W - 1);

    srx_state_e        state, nxt;
    logic [IW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HUNT:  if (!rx_s) nxt = ST_START;
            ST_START: if (tick)  nxt = rx_s ? ST_HUNT : ST_DATA;
            ST_DATA:  if (tick && bit_idx == LAST_IDX) nxt = ST_STOP;
            ST_STOP:  if (tick)  nxt = ST_HUNT;
            default:  nxt = ST_HUNT;
        endcase
    end

    // outputs: bit counter, shifter, accept pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            shreg   <= '0;
            byte_ok <= 1'b0;
        end else begin
            byte_ok <= 1'b0;
            unique case (state)
                ST_HUNT:  bit_idx <= '0;
                ST_START: bit_idx <= '0;
                ST_DATA: if (tick) begin
                    shreg   <= {rx_s, shreg[DATA_W-1:1]};
                    bit_idx <= bit_idx + 1'b1;
                end
                ST_STOP: if (tick) byte_ok <= rx_s;
                default: bit_idx <= '0;
            endcase
        end
    end

    assign hunting   = (state == ST_HUNT);
    assign byte_data = shreg;
endmodule

// File: rtl/srx_hold.sv
// Holding register: newest byte wins, read strobe clears the flag.
module srx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else if (load) begin
            data_o  <= load_data;
            valid_o <= 1'b1;
        end else if (rd_i) begin
            valid_o <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_rx_latest.sv
module serial_rx_latest #(
    parameter int CLK_HZ = 48_000_000,
    parameter int BAUD   = 921_600,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              rd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int BIT_CLKS  = CLK_HZ / BAUD;
    localparam int HALF_CLKS = BIT_CLKS / 2;

    logic              rx_s;
    logic              hunting;
    logic              bit_tick;
    logic              byte_ok;
    logic [DATA_W-1:0] byte_data;

    srx_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
    );

    srx_timer #(.BIT_CLKS(BIT_CLKS), .HALF_CLKS(HALF_CLKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(hunting), .tick(bit_tick)
    );

    srx_frame #(.DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .tick(bit_tick),
        .hunting(hunting), .byte_ok(byte_ok), .byte_data(byte_data)
    );

    srx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(byte_ok), .load_data(byte_data),
        .rd_i(rd_i), .data_o(data_o), .valid_o(valid_o)
    );
endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_i,
    input logic              load,
    input logic [DATA_W-1:0] load_data,
    input logic [DATA_W-1:0] data_o,
    input logic              valid_o,
    input logic              tick,
    input logic              hunting
);
    a_r7_read_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !load) |=> !valid_o);

    a_r8_load_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (valid_o && data_o == $past(load_data)));

    a_r5_data_moves_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(data_o));

    a_r3_flag_rises_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(load));

    a_r9_no_strobe_while_hunting: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |-> !tick);
endmodule

bind serial_rx_latest srx_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .load(byte_ok),
    .load_data(byte_data), .data_o(data_o), .valid_o(valid_o),
    .tick(bit_tick), .hunting(hunting)
);

// File: tb/serial_rx_latest_tb.sv
module serial_rx_latest_tb;
    localparam int CLK_HZ = 3_200_000;
    localparam int BAUD   = 100_000;
    localparam int BIT    = CLK_HZ / BAUD;
    localparam int HALF   = BIT / 2;
    localparam int LAT    = 4 + HALF + 9 * BIT;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       rx    = 1'b1;
    logic       rd    = 1'b0;
    logic [7:0] dout;
    logic       vld;

    serial_rx_latest #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .rd_i(rd),
        .data_o(dout), .valid_o(vld)
    );

    int    vectors  = 0;
    int    fails    = 0;
    int    cyc      = 0;
    int    fall_cyc = 0;
    int    last_lat = -1;
    string tag      = "R1";
    logic  prev_v   = 1'b0;
    bit    done     = 1'b0;

    // behavioural reference model, one step per clock edge
    logic       h1 = 1'b1, h2 = 1'b1, d;
    bit         busy = 1'b0, pend = 1'b0;
    int         t = 0, k = 0;
    logic [7:0] mb = '0, pb = '0, exp_d = '0;
    logic       exp_v = 1'b0;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            h1 = 1'b1; h2 = 1'b1; busy = 0; pend = 0;
            exp_d = '0; exp_v = 1'b0;
        end else begin
            d  = h2;
            h2 = h1;
            h1 = rx;
            if (pend) begin
                exp_d = pb; exp_v = 1'b1; pend = 0;
            end else if (rd) begin
                exp_v = 1'b0;
            end
            if (!busy) begin
                if (d == 1'b0) begin busy = 1; t = 0; end
            end else begin
                t++;
                if (t == HALF) begin
                    if (d != 1'b0) busy = 0;
                end else if (t > HALF && (t - HALF) % BIT == 0) begin
                    k = (t - HALF) / BIT;
                    if (k <= 8) mb[k-1] = d;
                    else begin
                        if (d == 1'b1) begin pend = 1; pb = mb; end
                        busy = 0;
                    end
                end
            end
        end
    end

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (dout !== exp_d || vld !== exp_v) begin
                fails++;
                $display("FAIL %s model: data=%02h valid=%0b expected data=%02h valid=%0b",
                         tag, dout, vld, exp_d, exp_v);
            end
            if (vld && !prev_v) last_lat = cyc - fall_cyc;
            prev_v = vld;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input int p, input logic stop_v);
        rx = 1'b0; fall_cyc = cyc;
        wait_n(p);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            wait_n(p);
        end
        rx = stop_v;
        wait_n(p);
        rx = 1'b1;
    endtask

    task automatic do_read();
        rd = 1'b1;
        wait_n(1);
        rd = 1'b0;
        wait_n(1);
    endtask

    task automatic report();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (100_000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        report();
    end

    initial begin
        logic [7:0] pat [5];
        pat = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81};
        wait_n(3);
        tag = "R1";
        chk(vld == 1'b0, "R1", "valid in reset", vld, 0);
        chk(dout == 8'h00, "R1", "data in reset", dout, 0);
        rst_n = 1'b1;
        wait_n(4);
        chk(vld == 1'b0 && dout == 8'h00, "R1", "idle after reset", {vld, dout}, 0);

        // R2: several patterns, read in between
        tag = "R2";
        foreach (pat[i]) begin
            send(pat[i], BIT, 1'b1);
            wait_n(2);
            chk(vld == 1'b1, "R2", "valid after frame", vld, 1);
            chk(dout == pat[i], "R2", "byte value", dout, pat[i]);
            do_read();
        end

        // R3 / R9: latency fixed for every start phase
        for (int off = 0; off < 6; off++) begin
            tag = (off == 0) ? "R3" : "R9";
            wait_n(3 + off);
            send(8'h5A + 8'(off), BIT, 1'b1);
            wait_n(2);
            chk(last_lat == LAT, tag, "latency to valid", last_lat, LAT);
            do_read();
        end

        // R4: short start glitch ignored (valid 0, data 5F held)
        tag = "R4";
        rx = 1'b0; wait_n(HALF - 6); rx = 1'b1;
        wait_n(3 * BIT);
        chk(vld == 1'b0, "R4", "valid after glitch", vld, 0);
        chk(dout == 8'h5F, "R4", "data after glitch", dout, 8'h5F);

        // R5: bad stop bit, with flag set and with flag clear
        tag = "R5";
        send(8'hC3, BIT, 1'b1);
        wait_n(2);
        send(8'h3C, BIT, 1'b0);
        wait_n(2 * BIT);
        chk(vld == 1'b1 && dout == 8'hC3, "R5", "state after framing error", {vld, dout}, 9'h1C3);
        do_read();
        send(8'h99, BIT, 1'b0);
        wait_n(2 * BIT);
        chk(vld == 1'b0 && dout == 8'hC3, "R5", "flag stays clear", {vld, dout}, 9'h0C3);

        // R6: overrun keeps the freshest byte
        tag = "R6";
        send(8'h11, BIT, 1'b1);
        send(8'h22, BIT, 1'b1);
        wait_n(2);
        chk(vld == 1'b1 && dout == 8'h22, "R6", "newest byte", {vld, dout}, 9'h122);

        // R7: read clears flag, data untouched; extra read harmless
        tag = "R7";
        do_read();
        chk(vld == 1'b0 && dout == 8'h22, "R7", "after read", {vld, dout}, 9'h022);
        do_read();
        chk(vld == 1'b0 && dout == 8'h22, "R7", "read while empty", {vld, dout}, 9'h022);

        // R8: read strobe on the exact load edge
        tag = "R8";
        send(8'h44, BIT, 1'b1);
        wait_n(2);
        fork
            send(8'h77, BIT, 1'b1);
            begin
                wait_n(LAT - 1);
                rd = 1'b1;
                wait_n(1);
                rd = 1'b0;
                chk(vld == 1'b1 && dout == 8'h77, "R8", "read meets load", {vld, dout}, 9'h177);
            end
        join
        wait_n(2);
        do_read();

        // R10: back-to-back frames from a sender 3 % fast, then 3 % slow
        tag = "R10";
        send(8'h96, BIT - 1, 1'b1);
        chk(dout == 8'h96 && vld, "R10", "fast sender byte 1", dout, 8'h96);
        send(8'h6D, BIT - 1, 1'b1);
        chk(dout == 8'h6D && vld, "R10", "fast sender byte 2", dout, 8'h6D);
        send(8'hB4, BIT + 1, 1'b1);
        chk(dout == 8'hB4 && vld, "R10", "slow sender byte 1", dout, 8'hB4);
        send(8'h2B, BIT + 1, 1'b1);
        chk(dout == 8'h2B && vld, "R10", "slow sender byte 2", dout, 8'h2B);

        wait_n(BIT);
        report();
    end
endmodule